// File: doc/BRIEF.md
# Buffered PWM Timer with Register Interface

A single-channel pulse-width modulator whose pulse width and repetition length are counts of the block clock, programmed through three word registers on a simple address/strobe interface. Software stages a new high-time count and a new period count in buffer registers. Those values reach the running counter only when a control write starts the timer, or when the counter finishes a period. A waveform in progress is therefore never shortened or torn.

The control word turns the counter on and off and gates the output pin (the gate is active low). It can also flip the output sense, stop the timer after one period, hold the counter at zero, and raise a level interrupt at every period boundary. Two further control bits are plain storage that reads back as written. While the counter is off, the pin is low regardless of the inversion setting.

Top module: `bufpwm`

## Requirements
- R1: After reset, all three registers read 0 and both `pwm_o` and `irq_o` are 0.
- R2: Address 0x4 holds the high-time buffer, 0x8 the period buffer and 0xC the control word. In the control word, bits 0, 3, 4, 5, 7, 8, 9 and 10 read back as last written, bit 6 reads the interrupt flag, and all other bits read 0. Any other address reads 0, and `rdata_o` is 0 while `rd_i` is low.
- R3: The buffers keep only the low CNT_W bits of the write data and read back zero-extended.
- R4: A control write with bit 0 set copies both buffers into the active counts and restarts the period. The output reflects count 0 in the cycle after that write edge. With bit 9 clear, it is then high for D cycles out of every P cycles, starting at count 0.
- R5: With control bit 9 set, the output is low for the first D cycles of each period and high for the rest.
- R6: While control bit 0 is 0, `pwm_o` is 0 whatever bit 9 holds.
- R7: Buffer writes made while the counter runs take effect at the first period boundary after them, never in mid-period.
- R8: Each period boundary sets control bit 6. Writing 1 to bit 6 clears it. `irq_o` is 1 exactly while bit 6 and bit 5 are both 1.
- R9: With control bit 4 set, the block clears bit 0 at the end of the first full period, and the output then stays 0.
- R10: While control bit 7 is 1, the counter stays at count 0, so the output holds the level of count 0 and no period boundary occurs.
- R11: While control bit 3 is 1, `pwm_o` is 0.
- R12: A period count of 0 or 1 makes every cycle a period boundary. A high-time count of at least the period count keeps the output active for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; counts are in cycles of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; read data is combinational |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, 0 when not reading |
| pwm_o | output | 1 | Modulated output |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with CNT_W = 8 and the default 32-bit data path. The narrow counter makes the dropping of upper write-data bits visible on readback, while each programmed period stays a handful of cycles long. With these sizes a table of waveforms can be walked quickly: normal and inverted sense, gated output, held counter, disabled counter, and the degenerate period counts 0 and 1. Directed sequences then cover a buffer write landing mid-period, the flag and its clear, and the one-shot stop.

// File: rtl/bufpwm_pkg.sv
package bufpwm_pkg;
   // register offsets; software relies on these
   localparam int OFS_DUTY = 4;
   localparam int OFS_PER  = 8;
   localparam int OFS_CTRL = 12;

   // control word bit positions
   localparam int CTRL_W = 11;
   localparam int B_EN   = 0;
   localparam int B_OEN  = 3;
   localparam int B_ONE  = 4;
   localparam int B_IE   = 5;
   localparam int B_FLAG = 6;
   localparam int B_HOLD = 7;
   localparam int B_CAP  = 8;
   localparam int B_INV  = 9;
   localparam int B_DZ   = 10;

   // bits that are plain read/write storage (flag and enable handled apart)
   localparam logic [CTRL_W-1:0] CTRL_RW_MASK =
      CTRL_W'((1 << B_OEN) | (1 << B_ONE) | (1 << B_IE) | (1 << B_HOLD) |
              (1 << B_CAP) | (1 << B_INV) | (1 << B_DZ));
endpackage

// File: rtl/bufpwm_regs.sv
module bufpwm_regs
   import bufpwm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wrap_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CNT_W-1:0]  duty_buf_o,
   output logic [CNT_W-1:0]  per_buf_o,
   output logic              start_o,
   output logic              en_o,
   output logic              oe_n_o,
   output logic              one_shot_o,
   output logic              ie_o,
   output logic              flag_o,
   output logic              hold_o,
   output logic              inv_o
);
   logic                wr_ctrl;
   logic                wr_duty;
   logic                wr_per;
   logic [CTRL_W-1:0]   ctrl_q;
   logic [CNT_W-1:0]    duty_q;
   logic [CNT_W-1:0]    per_q;

   assign wr_ctrl = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign wr_duty = wr_i && (addr_i == ADDR_W'(OFS_DUTY));
   assign wr_per  = wr_i && (addr_i == ADDR_W'(OFS_PER));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         per_q  <= '0;
      end else begin
         if (wr_duty) duty_q <= wdata_i[CNT_W-1:0];
         if (wr_per)  per_q  <= wdata_i[CNT_W-1:0];
      end
   end

   // one storage variant per control bit
   for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
      if (b == B_FLAG) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= 1'b0;
            else if (wrap_i)               q <= 1'b1;
            else if (wr_ctrl && wdata_i[b]) q <= 1'b0;
         end
         assign ctrl_q[b] = q;
      end else if (b == B_EN) begin : g_en
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= 1'b0;
            else if (wr_ctrl)                    q <= wdata_i[b];
            else if (wrap_i && ctrl_q[B_ONE])    q <= 1'b0;
         end
         assign ctrl_q[b] = q;
      end else if (CTRL_RW_MASK[b]) begin : g_rw
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= 1'b0;
            else if (wr_ctrl) q <= wdata_i[b];
         end
         assign ctrl_q[b] = q;
      end else begin : g_none
         assign ctrl_q[b] = 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (addr_i == ADDR_W'(OFS_DUTY))      rdata_o = DATA_W'(duty_q);
         else if (addr_i == ADDR_W'(OFS_PER))  rdata_o = DATA_W'(per_q);
         else if (addr_i == ADDR_W'(OFS_CTRL)) rdata_o = DATA_W'(ctrl_q);
      end
   end

   assign duty_buf_o = duty_q;
   assign per_buf_o  = per_q;
   assign start_o    = wr_ctrl && wdata_i[B_EN];
   assign en_o       = ctrl_q[B_EN];
   assign oe_n_o     = ctrl_q[B_OEN];
   assign one_shot_o = ctrl_q[B_ONE];
   assign ie_o       = ctrl_q[B_IE];
   assign flag_o     = ctrl_q[B_FLAG];
   assign hold_o     = ctrl_q[B_HOLD];
   assign inv_o      = ctrl_q[B_INV];

   assert_flag_on_wrap_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> flag_o);
   assert_flag_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata_i[B_FLAG] && !wrap_i) |=> !flag_o);
   assert_one_shot_stop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && one_shot_o && !wr_ctrl) |=> !en_o);
endmodule

// File: rtl/bufpwm_timer.sv
module bufpwm_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] duty_buf_i,
   input  logic [CNT_W-1:0] per_buf_i,
   input  logic             start_i,
   input  logic             en_i,
   input  logic             oe_n_i,
   input  logic             hold_i,
   input  logic             inv_i,
   output logic             wrap_o,
   output logic             pwm_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] duty_a;
   logic [CNT_W-1:0] per_a;
   logic             last;
   logic             level;

   // periods of 0 or 1 collapse to a single cycle
   assign last   = (per_a <= ONE) || (cnt_q == per_a - ONE);
   assign wrap_o = en_i && !hold_i && !start_i && last;
   assign level  = (cnt_q < duty_a) ^ inv_i;
   assign pwm_o  = en_i && !oe_n_i && level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_a <= '0;
         per_a  <= '0;
      end else if (start_i) begin
         cnt_q  <= '0;
         duty_a <= duty_buf_i;
         per_a  <= per_buf_i;
      end else if (hold_i) begin
         cnt_q  <= '0;
      end else if (en_i) begin
         if (last) begin
            cnt_q  <= '0;
            duty_a <= duty_buf_i;
            per_a  <= per_buf_i;
         end else begin
            cnt_q  <= cnt_q + ONE;
         end
      end
   end

   assert_cnt_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q < per_a) || (cnt_q == '0));
   assert_restart_load_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == '0 && duty_a == $past(duty_buf_i) && per_a == $past(per_buf_i)));
   assert_hold_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !start_i) |=> (cnt_q == '0));
   assert_active_steady_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !wrap_o) |=> ($stable(duty_a) && $stable(per_a)));
endmodule

// File: rtl/bufpwm.sv
module bufpwm
   import bufpwm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pwm_o,
   output logic              irq_o
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("bufpwm: CNT_W must lie between 2 and DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("bufpwm: DATA_W too narrow for the control word");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("bufpwm: ADDR_W must reach offset 0xC");
   end

   logic [CNT_W-1:0] duty_buf;
   logic [CNT_W-1:0] per_buf;
   logic start, en, oe_n, one_shot, ie, flag, hold, inv, wrap;

   bufpwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .wdata_i    (wdata_i),
      .wrap_i     (wrap),
      .rdata_o    (rdata_o),
      .duty_buf_o (duty_buf),
      .per_buf_o  (per_buf),
      .start_o    (start),
      .en_o       (en),
      .oe_n_o     (oe_n),
      .one_shot_o (one_shot),
      .ie_o       (ie),
      .flag_o     (flag),
      .hold_o     (hold),
      .inv_o      (inv)
   );

   bufpwm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_buf_i (duty_buf),
      .per_buf_i  (per_buf),
      .start_i    (start),
      .en_i       (en),
      .oe_n_i     (oe_n),
      .hold_i     (hold),
      .inv_i      (inv),
      .wrap_o     (wrap),
      .pwm_o      (pwm_o)
   );

   assign irq_o = flag && ie;

   assert_off_after_one_shot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (one_shot && wrap && !(wr_i && addr_i == ADDR_W'(OFS_CTRL))) |=> !pwm_o);
endmodule

// File: tb/bufpwm_bench.sv
`timescale 1ns/1ps
module bufpwm_bench;
   localparam int CNT_W  = 8;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;
   localparam int WIN    = 20;
   localparam int NVEC   = 10;

   // {duty, period, control, expected high cycles in WIN samples}
   localparam logic [127:0] VEC [NVEC] = '{
      {32'd3, 32'd8,  32'h001, 32'd9 },   // R4 normal
      {32'd5, 32'd5,  32'h001, 32'd20},   // R12 duty == period
      {32'd0, 32'd6,  32'h001, 32'd0 },   // R4 zero duty
      {32'd2, 32'd4,  32'h201, 32'd10},   // R5 inverted
      {32'd3, 32'd8,  32'h209, 32'd0 },   // R11 gated
      {32'd1, 32'd1,  32'h001, 32'd20},   // R12 period 1
      {32'd0, 32'd0,  32'h201, 32'd20},   // R12 period 0, inverted
      {32'd7, 32'd10, 32'h001, 32'd14},   // R4 longer period
      {32'd4, 32'd6,  32'h200, 32'd0 },   // R6 disabled, inverted
      {32'd2, 32'd3,  32'h081, 32'd20}    // R10 counter held
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              wr_i = 1'b0;
   logic              rd_i = 1'b0;
   logic [DATA_W-1:0] wdata_i = '0;
   logic [DATA_W-1:0] rdata_o;
   logic              pwm_o;
   logic              irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bufpwm #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bufpwm (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // every task starts and ends just after a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      addr_i = ADDR_W'(a); wdata_i = d; wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr_i = ADDR_W'(a); rd_i = 1'b1;
      #1 d = rdata_o;
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int k = 0; k < n; k++) begin
         h += int'(pwm_o);
         @(negedge clk);
      end
   endtask

   initial begin
      logic [31:0] d;
      int h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 pwm", 32'(pwm_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      rd(4, d);  chk("R1 duty", d, 0);
      rd(8, d);  chk("R1 period", d, 0);
      rd(12, d); chk("R1 ctrl", d, 0);

      // vector table: waveform counts
      for (int v = 0; v < NVEC; v++) begin
         wr(4,  VEC[v][127:96]);
         wr(8,  VEC[v][95:64]);
         wr(12, VEC[v][63:32]);
         count_high(WIN, h);
         chk($sformatf("R4/R5/R6/R10/R11/R12 vector %0d", v), 32'(h), VEC[v][31:0]);
      end

      // R8 flag set by earlier runs, interrupt masked
      rd(12, d); chk("R8 flag readback", d, 32'h0C1);
      chk("R8 masked irq", 32'(irq_o), 0);

      // R2 control readback and decode
      wr(12, 32'h0000_0FFE);
      rd(12, d); chk("R2 ctrl bits", d, 32'h7B8);
      rd(0, d);  chk("R2 unmapped", d, 0);
      addr_i = ADDR_W'(12); #1 chk("R2 no read strobe", rdata_o, 0);
      @(negedge clk);

      // R3 width truncation
      wr(4, 32'h1A5); rd(4, d); chk("R3 duty", d, 32'hA5);
      wr(8, 32'h3C7); rd(8, d); chk("R3 period", d, 32'hC7);

      // R4 start and R7 mid-period buffer write
      wr(4, 2); wr(8, 4); wr(12, 32'h1);
      chk("R4 first cycle", 32'(pwm_o), 1);
      wr(4, 3);
      count_high(3, h); chk("R7 current period", 32'(h), 1);
      count_high(4, h); chk("R7 next period", 32'(h), 3);

      // R8 flag and interrupt
      wr(4, 1); wr(8, 3); wr(12, 32'h61);
      chk("R8 irq k0", 32'(irq_o), 0);
      @(negedge clk); @(negedge clk);
      chk("R8 irq before wrap", 32'(irq_o), 0);
      @(negedge clk);
      chk("R8 irq after wrap", 32'(irq_o), 1);
      rd(12, d); chk("R8 ctrl with flag", d, 32'h61);
      wr(12, 32'h61);
      chk("R8 irq cleared", 32'(irq_o), 0);

      // R9 single pulse
      wr(4, 2); wr(8, 3); wr(12, 32'h51);
      count_high(10, h); chk("R9 one pulse", 32'(h), 2);
      rd(12, d); chk("R9 enable cleared", d, 32'h50);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule